// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog counter with a legal refresh window. It advances on a single-cycle tick enable, so the count rate is set by a slow, independent time base rather than by the processor clock. With the default settings one tick stands for one second. Every start and every accepted refresh opens a new window. A refresh that arrives before the programmable minimum count has elapsed is a fault. Letting the programmable timeout count run out is also a fault.

One mode input chooses how a fault is reported. In reset mode a fault produces a reset pulse of fixed length, and the window reopens once the pulse ends. In interrupt mode a fault sets a sticky interrupt that holds until software clears it, and the window reopens at once. While the enable input is low the count is held at zero and no fault can occur. Raising the enable opens a fresh window.

Top module: `wwdt_core`

## Requirements
- R1: While `rst` is high, at the next clock edge `wd_rst` and `wd_irq` go low and the elapsed count clears to zero.
- R2: The elapsed count advances only on cycles where `tick_en` is high. With no refresh, the timeout fault happens on exactly the `max_cnt`-th tick after the window opens, however many clock cycles separate the ticks.
- R3: A refresh (`kick` high for a cycle) whose elapsed tick count is at least `min_cnt` is accepted, including a count exactly equal to `min_cnt`, as long as it does not land on the timeout tick. An accepted refresh raises no fault and restarts the count from zero.
- R4: When `max_cnt` ticks pass with no accepted refresh, a fault is raised on the edge of the last tick.
- R5: A refresh whose elapsed tick count is below `min_cnt` raises a fault.
- R6: A refresh that arrives in the same cycle as the tick that completes the timeout counts as a timeout fault, not as a refresh.
- R7: With `irq_mode` = 0, a fault drives `wd_rst` high starting at the edge of the fault for exactly `RST_CYC` clock cycles. During the pulse the count is held at zero and refreshes are ignored. The window reopens when the pulse ends.
- R8: With `irq_mode` = 1, a fault sets `wd_irq` at the edge of the fault and leaves `wd_rst` low. `wd_irq` stays high until it is cleared. A fault in the same cycle as `irq_clr` leaves it set.
- R9: `irq_clr` high for one cycle, with no fault in that cycle, drives `wd_irq` low at the next edge.
- R10: While `wd_en` is low the count is held at zero and refreshes and ticks raise no fault. After `wd_en` rises, the next timeout comes exactly `max_cnt` ticks later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle time-base tick |
| kick | input | 1 | Refresh strobe, one cycle |
| wd_en | input | 1 | Watchdog enable |
| irq_mode | input | 1 | Fault action: 0 gives a reset pulse, 1 gives a sticky interrupt |
| irq_clr | input | 1 | Clears the sticky interrupt |
| min_cnt | input | CNT_W | Ticks that must elapse before a refresh is legal |
| max_cnt | input | CNT_W | Ticks until the timeout fault (greater than min_cnt) |
| wd_rst | output | 1 | Registered reset pulse |
| wd_irq | output | 1 | Registered sticky interrupt |

## Verification
The hardest case to reach is a refresh that coincides with the tick that completes the timeout, because the bench must place the strobe on one exact cycle out of many. The stimulus drives `kick` from the bench model's own elapsed count, so it can aim at any chosen count: one below the minimum, exactly the minimum, or the last tick. A refresh sent during a reset pulse, a clear that meets a fault in the same cycle, and a slowed tick rate are produced the same way. On every clock the bench compares both outputs with the model.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  // Outcome of the window check in one cycle
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_EARLY = 2'd1,
    FLT_LATE  = 2'd2
  } flt_kind_e;
endpackage

// File: rtl/wwdt_ticker.sv
module wwdt_ticker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != CNT_TOP) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R10
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt_q == '0);

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run && !restart && !tick |=> $stable(cnt_q));
endmodule

// File: rtl/wwdt_window.sv
module wwdt_window
  import wwdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             active,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] min_cnt,
  input  logic [CNT_W-1:0] max_cnt,
  output flt_kind_e        kind_o,
  output logic             good_o
);
  logic [CNT_W:0] cnt_nxt;
  logic           late;
  logic           too_soon;

  always_comb begin
    cnt_nxt  = {1'b0, cnt} + 1'b1;
    // Timeout tick takes priority over any refresh in the same cycle
    late     = active && tick && (cnt_nxt >= {1'b0, max_cnt});
    too_soon = cnt < min_cnt;
    if (late) begin
      kind_o = FLT_LATE;
    end else if (active && kick && too_soon) begin
      kind_o = FLT_EARLY;
    end else begin
      kind_o = FLT_NONE;
    end
    good_o = active && kick && !late && !too_soon;
  end
endmodule

// File: rtl/wwdt_signal.sv
module wwdt_signal
  import wwdt_pkg::*;
#(
  parameter int RST_CYC = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  flt_kind_e kind,
  input  logic      irq_sel,
  input  logic      irq_clr,
  output logic      busy_o,
  output logic      rst_o,
  output logic      irq_o
);
  localparam int PW = $clog2(RST_CYC + 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          fault;

  always_comb begin
    fault = kind != FLT_NONE;
    if (fault && !irq_sel) begin
      pcnt_d = PW'(RST_CYC);
    end else if (pcnt_q != '0) begin
      pcnt_d = pcnt_q - 1'b1;
    end else begin
      pcnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      rst_o  <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      rst_o  <= pcnt_d != '0;
      if (fault && irq_sel) begin
        irq_o <= 1'b1;
      end else if (irq_clr) begin
        irq_o <= 1'b0;
      end
    end
  end

  assign busy_o = pcnt_q != '0;

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    fault && !irq_sel |=> rst_o);

  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    fault && irq_sel |=> irq_o);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o && !irq_clr |=> irq_o);

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    irq_clr && !(fault && irq_sel) |=> !irq_o);
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RST_CYC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             kick,
  input  logic             wd_en,
  input  logic             irq_mode,
  input  logic             irq_clr,
  input  logic [CNT_W-1:0] min_cnt,
  input  logic [CNT_W-1:0] max_cnt,
  output logic             wd_rst,
  output logic             wd_irq
);
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic             active;
  logic             good;
  flt_kind_e        kind;

  // Window is live only when enabled and no reset pulse is running
  assign active = wd_en && !busy;

  wwdt_ticker #(.CNT_W(CNT_W)) u_ticker (
    .clk     (clk),
    .rst     (rst),
    .run     (active),
    .tick    (tick_en),
    .restart (good || (kind != FLT_NONE)),
    .cnt_o   (cnt)
  );

  wwdt_window #(.CNT_W(CNT_W)) u_window (
    .active  (active),
    .tick    (tick_en),
    .kick    (kick),
    .cnt     (cnt),
    .min_cnt (min_cnt),
    .max_cnt (max_cnt),
    .kind_o  (kind),
    .good_o  (good)
  );

  wwdt_signal #(.RST_CYC(RST_CYC)) u_signal (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .irq_sel (irq_mode),
    .irq_clr (irq_clr),
    .busy_o  (busy),
    .rst_o   (wd_rst),
    .irq_o   (wd_irq)
  );

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> kind == FLT_NONE && !good);

  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wd_en |-> kind == FLT_NONE);
endmodule

// File: tb/sim_wwdt_core.sv
module sim_wwdt_core;
  localparam int CW = 8;
  localparam int RC = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic tick_en = 1'b0, kick = 1'b0, wd_en = 1'b0;
  logic irq_mode = 1'b0, irq_clr = 1'b0;
  logic [CW-1:0] min_cnt = 8'd4, max_cnt = 8'd16;
  logic wd_rst, wd_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt = 0, m_pulse = 0;
  bit m_irq = 0, m_late, m_early, m_good, m_busy;
  int tick_div = 1, tick_ph = 0, t_seen = 0;

  always #2 clk = ~clk;

  wwdt_core #(.CNT_W(CW), .RST_CYC(RC)) u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .kick(kick), .wd_en(wd_en),
    .irq_mode(irq_mode), .irq_clr(irq_clr), .min_cnt(min_cnt),
    .max_cnt(max_cnt), .wd_rst(wd_rst), .wd_irq(wd_irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  // tick generator
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_div;
    tick_en = (tick_ph == 0);
  end

  always @(posedge clk) if (tick_en) t_seen++;

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pulse = 0; m_irq = 0;
    end else begin
      m_busy  = m_pulse > 0;
      m_late  = wd_en && !m_busy && tick_en && (m_cnt + 1 >= int'(max_cnt));
      m_early = wd_en && !m_busy && kick && !m_late && (m_cnt < int'(min_cnt));
      m_good  = wd_en && !m_busy && kick && !m_late && (m_cnt >= int'(min_cnt));
      if ((m_late || m_early) && irq_mode) m_irq = 1;
      else if (irq_clr) m_irq = 0;
      if ((m_late || m_early) && !irq_mode) m_pulse = RC;
      else if (m_pulse > 0) m_pulse--;
      if (!wd_en || m_busy || m_late || m_early || m_good) m_cnt = 0;
      else if (tick_en && m_cnt < 255) m_cnt++;
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (!done) begin
    chk(wd_rst === (m_pulse > 0), cur_req, "wd_rst vs model", int'(wd_rst), int'(m_pulse > 0));
    chk(wd_irq === m_irq, cur_req, "wd_irq vs model", int'(wd_irq), int'(m_irq));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick_when(input int v);
    while (m_cnt != v) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // counts high cycles of wd_rst from the current negedge; kicks once at kick_at
  task automatic pulse_len(input int kick_at, output int w);
    w = 0;
    while (wd_rst === 1'b1 && w < 100) begin
      kick = (w == kick_at);
      w++;
      @(negedge clk);
    end
    kick = 1'b0;
  endtask

  // counts negedges until wd_rst rises
  task automatic wait_rst(output int w);
    w = 0;
    while (wd_rst !== 1'b1 && w < 1000) begin
      @(negedge clk);
      w++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", "run hung", 0, 1);
    finish_run();
  end

  initial begin
    int w;
    cyc(4);
    chk(wd_rst == 1'b0 && wd_irq == 1'b0, "R1", "outputs in reset", int'(wd_rst | wd_irq), 0);
    rst = 1'b0;
    wd_en = 1'b1;

    // R3: refresh exactly at min, then later in window
    cur_req = "R3";
    kick_when(4);
    chk(wd_rst == 1'b0, "R3", "refresh at min accepted", int'(wd_rst), 0);
    kick_when(10);
    kick_when(4);
    cyc(2);
    chk(wd_rst == 1'b0, "R3", "repeated valid refresh", int'(wd_rst), 0);

    // R5: early refresh
    cur_req = "R5";
    kick_when(3);
    chk(wd_rst == 1'b1, "R5", "early refresh fault", int'(wd_rst), 1);
    cur_req = "R7";
    pulse_len(-1, w);
    chk(w == RC, "R7", "reset pulse length", w, RC);

    // R4: timeout right after pulse ends
    cur_req = "R4";
    wait_rst(w);
    chk(w == 16, "R4", "cycles to timeout", w, 16);
    pulse_len(-1, w);

    // R6: refresh on the timeout tick
    cur_req = "R6";
    kick_when(15);
    chk(wd_rst == 1'b1, "R6", "refresh on timeout tick faults", int'(wd_rst), 1);
    pulse_len(-1, w);
    chk(w == RC, "R6", "pulse after timeout-tick refresh", w, RC);

    // R2: slow ticks
    cur_req = "R2";
    tick_div = 3;
    t_seen = 0;
    wait_rst(w);
    chk(t_seen == 16, "R2", "ticks to timeout at slow rate", t_seen, 16);
    chk(w >= 40, "R2", "cycles to timeout at slow rate", w, 46);
    pulse_len(-1, w);
    tick_div = 1;
    cyc(3);

    // R8: interrupt mode
    cur_req = "R8";
    irq_mode = 1'b1;
    kick_when(2);
    chk(wd_irq == 1'b1, "R8", "irq set on fault", int'(wd_irq), 1);
    chk(wd_rst == 1'b0, "R8", "no reset in irq mode", int'(wd_rst), 0);
    cyc(20);
    chk(wd_irq == 1'b1, "R8", "irq sticky", int'(wd_irq), 1);

    // R9: clear
    cur_req = "R9";
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(wd_irq == 1'b0, "R9", "irq cleared", int'(wd_irq), 0);

    // R8: fault beats clear in the same cycle
    cur_req = "R8";
    while (m_cnt != 1) @(negedge clk);
    kick = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    kick = 1'b0; irq_clr = 1'b0;
    chk(wd_irq == 1'b1, "R8", "fault wins over clear", int'(wd_irq), 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;

    // R10: disabled, kicks ignored
    cur_req = "R10";
    wd_en = 1'b0;
    irq_mode = 1'b0;
    repeat (10) begin
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      cyc(3);
    end
    chk(wd_rst == 1'b0 && wd_irq == 1'b0, "R10", "no fault while disabled", int'(wd_rst | wd_irq), 0);
    wd_en = 1'b1;
    wait_rst(w);
    chk(w == 16, "R10", "fresh window after enable", w, 16);

    // R7: refresh during pulse ignored, window restarts after
    cur_req = "R7";
    pulse_len(3, w);
    chk(w == RC, "R7", "pulse length with refresh inside", w, RC);
    wait_rst(w);
    chk(w == 16, "R7", "window restart after pulse", w, 16);
    pulse_len(-1, w);
    cyc(4);
    finish_run();
  end
endmodule